// File: doc/BRIEF.md
# Touch-Panel Sampling Converter Front End

This block is a small register-mapped converter front end for a 4-wire resistive touch panel. Software selects a channel and sets a start bit. A fixed number of clocks later the block takes a 10-bit reading from an external digital sample bus, which stands in for the analog converter. It stores the reading in the chosen channel's result register, raises a done flag and can pulse an interrupt. Channels 0 and 1 belong to the vertical panel axis. Channels 2 and 3 belong to the horizontal axis.

The block also watches writes to the port that drives the panel electrodes. Three drive codes set an axis mode. The mode decides whether a finished conversion stores the raw reading or its complement. This lets the block follow the panel's electrode polarity without any help from software. Every other drive code leaves the mode as it was.

Top module: `panel_adc`

## Requirements
- R1: After reset, all ten register offsets read 0x00, the axis mode is raw and `convIrq` is low.
- R2: A result register of channel c occupies offsets 2c and 2c+1. Offset 2c reads sample bits 9..2. Offset 2c+1 reads sample bits 1..0 in bits 7..6, and its bits 5..0 read as zero.
- R3: The status register is at offset 8: bit 7 is done, bit 6 is interrupt enable, bit 5 is start/busy, and bits 1..0 are the channel. Writing it with bit 5 set while idle starts a conversion. Bit 5 then reads 1 until completion. Exactly CONV_DELAY clocks after the write edge, the sample is stored, bit 7 reads 1 and bit 5 reads 0.
- R4: A conversion writes only the result register of the channel held in status bits 1..0. The other channels keep their values.
- R5: Drive code 0x0C, written to the electrode port, selects raw mode. In raw mode every channel stores the reading unchanged.
- R6: Drive code 0x09 selects vertical-inverted mode. Channels 0 and 1 store 0x3FF minus the reading, and channels 2 and 3 store it raw.
- R7: Drive code 0x06 selects horizontal-inverted mode. Channels 2 and 3 store 0x3FF minus the reading, and channels 0 and 1 store it raw.
- R8: Any other drive code leaves the current axis mode unchanged.
- R9: While a conversion is busy, a status write with bit 5 set does not restart it. A channel field written during that time is ignored. Completion time and target channel stay as they were.
- R10: A status write with bit 7 = 0 clears done only if the status register was read (`regRdEn`) while done was 1. Without that read, the write leaves done at 1. Writing 1 to bit 7 never sets it.
- R11: `convIrq` pulses high for one clock, in the same cycle that done sets, only if bit 6 was 1. With bit 6 = 0 no pulse occurs.
- R12: Offset 9 is a plain 8-bit control register that reads back what was written. Offsets 10..15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regSel | input | 4 | Register offset for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (arms done clearing) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regSel` (combinational) |
| drvWrEn | input | 1 | Electrode port write strobe |
| drvWrData | input | 8 | Electrode drive code |
| sampleIn | input | 10 | Digital stand-in for the converter output |
| convIrq | output | 1 | One-clock conversion-complete interrupt pulse |

## Verification
The bench goes after the cycle of completion. A counter that is one clock off shows up as an interrupt in the wrong cycle. It also covers the axis-to-channel pairing under each drive code. A design with the pairs swapped, or with the complement applied to the wrong axis, stores the reading where the bench expects 0x3FF minus it. An unrecognised drive code that is not ignored falls back to raw mode, and the bench sees the complement vanish. A restart honoured during a busy conversion moves both the completion cycle and the target channel. The done-clear handshake is tried both with and without the prior read, so a flag that clears too easily is caught.

// File: rtl/panel_adc_pkg.sv
package panel_adc_pkg;

  typedef enum logic [1:0] {
    AXIS_RAW   = 2'd0,
    AXIS_INV_V = 2'd1,
    AXIS_INV_H = 2'd2
  } axisMode_e;

  localparam logic [7:0] DRV_CODE_RAW   = 8'h0C;
  localparam logic [7:0] DRV_CODE_INV_V = 8'h09;
  localparam logic [7:0] DRV_CODE_INV_H = 8'h06;

  localparam int DONE_BIT  = 7;
  localparam int IRQEN_BIT = 6;
  localparam int START_BIT = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic invert;
  } dpStrobe_t;

endpackage

// File: rtl/panel_adc_ctrl.sv
module panel_adc_ctrl
  import panel_adc_pkg::*;
#(
  parameter int CHANNELS   = 4,
  parameter int CONV_DELAY = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        statusWr,
  input  logic                        statusRd,
  input  logic                        wrDoneBit,
  input  logic                        wrIrqEn,
  input  logic                        wrStart,
  input  logic [$clog2(CHANNELS)-1:0] wrChan,
  input  logic                        drvWrEn,
  input  logic [7:0]                  drvWrData,
  output dpStrobe_t                   strobe,
  output logic [$clog2(CHANNELS)-1:0] captureChan,
  output logic [7:0]                  statusByte,
  output logic                        convIrq
);

  localparam int CHAN_W = $clog2(CHANNELS);
  localparam int CNT_W  = $clog2(CONV_DELAY + 1);

  logic              busy;
  logic              doneFlag;
  logic              doneArmed;
  logic              irqEn;
  logic [CHAN_W-1:0] chanSel;
  logic [CNT_W-1:0]  cnt;
  axisMode_e         axisMode;

  logic startReq;
  logic finish;
  logic clearReq;
  logic isVertical;

  assign startReq   = statusWr && wrStart && !busy;
  assign finish     = busy && (cnt == CNT_W'(1));
  assign clearReq   = statusWr && !wrDoneBit && doneArmed;
  assign isVertical = !chanSel[CHAN_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      doneFlag  <= 1'b0;
      doneArmed <= 1'b0;
      irqEn     <= 1'b0;
      chanSel   <= '0;
      convIrq   <= 1'b0;
    end else begin
      if (startReq) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(CONV_DELAY);
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (finish) busy <= 1'b0;
      end
      if (statusWr) irqEn <= wrIrqEn;
      if (statusWr && !busy) chanSel <= wrChan;
      if (finish) doneFlag <= 1'b1;
      else if (clearReq) doneFlag <= 1'b0;
      if (clearReq && !finish) doneArmed <= 1'b0;
      else if (statusRd && doneFlag) doneArmed <= 1'b1;
      convIrq <= finish && irqEn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      axisMode <= AXIS_RAW;
    end else if (drvWrEn) begin
      case (drvWrData)
        DRV_CODE_RAW:   axisMode <= AXIS_RAW;
        DRV_CODE_INV_V: axisMode <= AXIS_INV_V;
        DRV_CODE_INV_H: axisMode <= AXIS_INV_H;
        default:        axisMode <= axisMode;
      endcase
    end
  end

  always_comb begin
    strobe.capture = finish;
    strobe.invert  = (axisMode == AXIS_INV_V &&  isVertical) ||
                     (axisMode == AXIS_INV_H && !isVertical);
    captureChan    = chanSel;
    statusByte                 = '0;
    statusByte[DONE_BIT]       = doneFlag;
    statusByte[IRQEN_BIT]      = irqEn;
    statusByte[START_BIT]      = busy;
    statusByte[CHAN_W-1:0]     = chanSel;
  end

  // R3: done only rises as a busy conversion ends
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneFlag) |-> $past(busy));

  // R9: a write during a busy conversion neither reloads the counter nor moves the channel
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt > CNT_W'(1) && statusWr) |=>
      (busy && cnt == $past(cnt) - CNT_W'(1) && chanSel == $past(chanSel)));

  // R11: interrupt only with enable set, together with done
  assert_irq_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    convIrq |-> (doneFlag && !busy && $past(irqEn)));

  // R11: single-cycle pulse
  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    convIrq |=> !convIrq);

  // R8: unknown drive codes keep the mode
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drvWrEn && drvWrData != DRV_CODE_RAW && drvWrData != DRV_CODE_INV_V &&
     drvWrData != DRV_CODE_INV_H) |=> axisMode == $past(axisMode));

endmodule

// File: rtl/panel_adc_dp.sv
module panel_adc_dp
  import panel_adc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CHANNELS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  dpStrobe_t                   strobe,
  input  logic [$clog2(CHANNELS)-1:0] captureChan,
  input  logic [SAMPLE_W-1:0]         sampleIn,
  input  logic                        ctrl2Wr,
  input  logic [7:0]                  regWrData,
  input  logic [ADDR_W-1:0]           regSel,
  input  logic [7:0]                  statusByte,
  output logic [7:0]                  regRdData
);

  localparam int CHAN_W     = $clog2(CHANNELS);
  localparam int STATUS_OFS = 2 * CHANNELS;
  localparam int CTRL2_OFS  = STATUS_OFS + 1;
  localparam int LO_BITS    = SAMPLE_W - 8;
  localparam logic [SAMPLE_W-1:0] FULL_SCALE = {SAMPLE_W{1'b1}};

  logic [SAMPLE_W-1:0] sampleReg [CHANNELS];
  logic [SAMPLE_W-1:0] storeVal;
  logic [7:0]          ctrl2Reg;
  logic [SAMPLE_W-1:0] selSample;
  logic [CHAN_W-1:0]   chIdx;

  assign storeVal = strobe.invert ? (FULL_SCALE - sampleIn) : sampleIn;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sampleReg[i] <= '0;
      else if (strobe.capture && captureChan == CHAN_W'(i)) sampleReg[i] <= storeVal;
    end

    // R4: a channel not addressed by the capture keeps its value
    assert_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(strobe.capture && captureChan == CHAN_W'(i)) |=> $stable(sampleReg[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl2Reg <= '0;
    else if (ctrl2Wr) ctrl2Reg <= regWrData;
  end

  assign chIdx     = regSel[CHAN_W:1];
  assign selSample = sampleReg[chIdx];

  always_comb begin
    regRdData = '0;
    if (regSel < ADDR_W'(STATUS_OFS)) begin
      if (regSel[0]) regRdData = {selSample[LO_BITS-1:0], {(8 - LO_BITS){1'b0}}};
      else           regRdData = selSample[SAMPLE_W-1 -: 8];
    end else if (regSel == ADDR_W'(STATUS_OFS)) begin
      regRdData = statusByte;
    end else if (regSel == ADDR_W'(CTRL2_OFS)) begin
      regRdData = ctrl2Reg;
    end
  end

endmodule

// File: rtl/panel_adc.sv
module panel_adc
  import panel_adc_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int CHANNELS   = 4,
  parameter int CONV_DELAY = 16,
  parameter int ADDR_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   regSel,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic                drvWrEn,
  input  logic [7:0]          drvWrData,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                convIrq
);

  localparam int CHAN_W     = $clog2(CHANNELS);
  localparam int STATUS_OFS = 2 * CHANNELS;
  localparam int CTRL2_OFS  = STATUS_OFS + 1;

  dpStrobe_t         strobe;
  logic [CHAN_W-1:0] captureChan;
  logic [7:0]        statusByte;
  logic              statusWr;
  logic              statusRd;
  logic              ctrl2Wr;

  assign statusWr = regWrEn && regSel == ADDR_W'(STATUS_OFS);
  assign statusRd = regRdEn && regSel == ADDR_W'(STATUS_OFS);
  assign ctrl2Wr  = regWrEn && regSel == ADDR_W'(CTRL2_OFS);

  panel_adc_ctrl #(
    .CHANNELS  (CHANNELS),
    .CONV_DELAY(CONV_DELAY)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .statusWr   (statusWr),
    .statusRd   (statusRd),
    .wrDoneBit  (regWrData[DONE_BIT]),
    .wrIrqEn    (regWrData[IRQEN_BIT]),
    .wrStart    (regWrData[START_BIT]),
    .wrChan     (regWrData[CHAN_W-1:0]),
    .drvWrEn    (drvWrEn),
    .drvWrData  (drvWrData),
    .strobe     (strobe),
    .captureChan(captureChan),
    .statusByte (statusByte),
    .convIrq    (convIrq)
  );

  panel_adc_dp #(
    .SAMPLE_W(SAMPLE_W),
    .CHANNELS(CHANNELS),
    .ADDR_W  (ADDR_W)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .captureChan(captureChan),
    .sampleIn   (sampleIn),
    .ctrl2Wr    (ctrl2Wr),
    .regWrData  (regWrData),
    .regSel     (regSel),
    .statusByte (statusByte),
    .regRdData  (regRdData)
  );

endmodule

// File: tb/test_panel_adc.sv
module test_panel_adc;

  localparam int DELAY = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] regSel = '0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       drvWrEn = 1'b0;
  logic [7:0] drvWrData = '0;
  logic [9:0] sampleIn = '0;
  logic       convIrq;

  int nChecks = 0;
  int nBad = 0;
  int cyc = 0;
  int benchMode = 0;           // 0 raw, 1 vertical inverted, 2 horizontal inverted
  logic [9:0] model [4];
  bit finished = 0;

  typedef struct {
    int         due;
    logic [7:0] hi;
    string      req;
  } sbItem_t;
  sbItem_t sb[$];

  panel_adc #(.CONV_DELAY(DELAY)) i_panel_adc (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .drvWrEn(drvWrEn), .drvWrData(drvWrData),
    .sampleIn(sampleIn), .convIrq(convIrq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] d);
    regSel = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [9:0] expOf(int ch, logic [9:0] s);
    bit inv;
    inv = (benchMode == 1 && ch < 2) || (benchMode == 2 && ch >= 2);
    return inv ? (10'h3FF - s) : s;
  endfunction

  task automatic drive(logic [7:0] code);
    @(negedge clk);
    drvWrData = code;
    drvWrEn = 1'b1;
    @(negedge clk);
    drvWrEn = 1'b0;
    // R5 R6 R7 R8: bench-side mode follows the code table
    if (code == 8'h0C) benchMode = 0;
    else if (code == 8'h09) benchMode = 1;
    else if (code == 8'h06) benchMode = 2;
  endtask

  task automatic regWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    regSel = a;
    regWrData = d;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // driver: starts a conversion and pushes the expected result
  task automatic conv(int ch, logic [9:0] s, bit ien, bit disturb, string req);
    logic [9:0] e;
    logic [7:0] d;
    int startCyc;
    e = expOf(ch, s);
    @(negedge clk);
    sampleIn = s;
    regSel = 4'd8;
    regWrData = {1'b0, ien, 1'b1, 3'b000, 2'(ch)};
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    startCyc = cyc;
    if (ien) sb.push_back('{startCyc + DELAY, e[9:2], req});
    peek(4'd8, d);
    chk("R3 busy bit during conversion", 16'(d[5]), 16'd1);
    regSel = 4'(2 * ch);
    if (disturb) begin
      repeat (5) @(negedge clk);
      regSel = 4'd8;
      regWrData = 8'b0110_0011;    // R9: restart aimed at channel 3
      regWrEn = 1'b1;
      @(negedge clk);
      regWrEn = 1'b0;
      regSel = 4'(2 * ch);
    end
    while (cyc < startCyc + DELAY + 2) @(negedge clk);
    model[ch] = e;
    for (int c = 0; c < 4; c++) begin
      peek(4'(2 * c), d);
      chk($sformatf("R4 %s ch%0d high byte", req, c), 16'(d), 16'(model[c][9:2]));
      peek(4'(2 * c + 1), d);
      chk($sformatf("R2 %s ch%0d low byte", req, c), 16'(d), 16'({model[c][1:0], 6'b0}));
    end
    peek(4'd8, d);
    chk("R3 done set, start clear", 16'(d[7:5] & 3'b101), 16'(3'b100));
  endtask

  // monitor: pops expected items as interrupts arrive
  always @(negedge clk) begin
    if (rst_n && convIrq) begin
      if (sb.size() == 0) begin
        chk("R11 unexpected interrupt", 16'd1, 16'd0);
      end else begin
        sbItem_t it;
        it = sb.pop_front();
        chk($sformatf("R3 completion cycle %s", it.req), 16'(cyc), 16'(it.due));
        chk($sformatf("%s stored high byte at interrupt", it.req), 16'(regRdData), 16'(it.hi));
      end
    end
  end

  initial begin
    logic [7:0] d;
    for (int c = 0; c < 4; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 10; a++) begin
      peek(4'(a), d);
      chk($sformatf("R1 reset offset %0d", a), 16'(d), 16'h00);
    end
    chk("R1 reset interrupt low", 16'(convIrq), 16'd0);

    conv(0, 10'h2A5, 1, 0, "R5 raw ch0");
    drive(8'h09);
    conv(1, 10'h123, 1, 0, "R6 vertical inverted ch1");
    conv(2, 10'h0F0, 1, 0, "R6 horizontal raw ch2");
    drive(8'h06);
    conv(3, 10'h155, 1, 0, "R7 horizontal inverted ch3");
    conv(0, 10'h3FF, 1, 0, "R7 vertical raw ch0");
    drive(8'h33);
    conv(2, 10'h001, 1, 0, "R8 mode kept after unknown code");
    drive(8'h0C);
    conv(2, 10'h001, 1, 0, "R5 raw after 0x0C");
    conv(1, 10'h2C7, 1, 1, "R9 restart ignored");
    conv(3, 10'h0AB, 0, 0, "R11 no interrupt when disabled");

    regWrite(4'd8, 8'h00);
    peek(4'd8, d);
    chk("R10 done kept without prior read", 16'(d[7]), 16'd1);
    @(negedge clk);
    regSel = 4'd8;
    regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    regWrite(4'd8, 8'h00);
    peek(4'd8, d);
    chk("R10 done cleared after read then write 0", 16'(d[7]), 16'd0);
    regWrite(4'd8, 8'h80);
    peek(4'd8, d);
    chk("R10 writing 1 does not set done", 16'(d[7]), 16'd0);

    regWrite(4'd9, 8'h5A);
    peek(4'd9, d);
    chk("R12 control register readback", 16'(d), 16'h5A);
    for (int a = 10; a < 16; a++) begin
      peek(4'(a), d);
      chk($sformatf("R12 unused offset %0d", a), 16'(d), 16'h00);
    end
    chk("R11 all expected interrupts seen", 16'(sb.size()), 16'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule